// File: doc/BRIEF.md
# Synchronous AHB-Lite to APB Bridge with Narrow-Write Lane Fill

This block sits between an AHB-Lite slave port and a set of APB peripherals that share one clock with it, so no synchronisation is needed. Each accepted AHB transfer becomes one APB transfer with a setup phase and an access phase. The AHB side sees wait states until the peripheral returns its ready. The peripheral region is split into fixed 1 KB slots. The slot index taken from the address drives exactly one line of a one-hot select vector.

APB registers are always accessed as 32-bit words. A byte or halfword write is therefore widened. The addressed lane of the AHB write data is copied into every matching lane of the APB write bus, and the APB address is forced to word alignment. Lanes are little endian: address offset 0 is bits 7:0. Read data goes back unchanged, and the master picks its own lane.

Two kinds of access are refused with a two-cycle AHB ERROR response and no APB activity. The first is an address outside the region or in a slot left unused by the slot mask. The second is any sub-word access to the configurable word-only window.

The controller has six states. IDLE accepts transfers with zero wait states. CAPTURE is entered for writes and latches the AHB write data. SETUP drives the select with enable low. ACCESS raises enable and holds until ready. ERR_WAIT and ERR_DONE are the two cycles of the error response. The transitions are:
- IDLE to CAPTURE on an accepted write.
- IDLE to SETUP on an accepted read.
- IDLE to ERR_WAIT on an accepted transfer that is refused.
- CAPTURE to SETUP.
- SETUP to ACCESS.
- ACCESS to itself while ready is low.
- ACCESS to IDLE, or directly to the next transfer's state, when ready is high.
- ERR_WAIT to ERR_DONE.
- ERR_DONE to IDLE or to the next transfer's state.

Top module: `apb_lane_bridge`

## Requirements
- R1: After reset, ahb_ready_out is 1, ahb_resp is 0, apb_sel is all zero and apb_enable is 0.
- R2: An accepted read gives one cycle with a select line high and apb_enable low. The next cycle has apb_enable high, with the same select and address.
- R3: ahb_ready_out stays low from the cycle after acceptance until the access cycle in which apb_ready is 1. In that cycle ahb_ready_out is 1 and ahb_rdata equals apb_rdata.
- R4: A word write (ahb_size 2) puts the AHB write data of the data-phase cycle unchanged on apb_wdata. apb_addr is the AHB address with bits 1:0 cleared. apb_write is 1.
- R5: A byte write (ahb_size 0) takes the byte at bits 8*addr[1:0]+7 down to 8*addr[1:0] and repeats it in all four byte lanes of apb_wdata.
- R6: A halfword write (ahb_size 1) takes bits 15:0 when addr[1] is 0, or bits 31:16 when it is 1, and repeats that halfword in both halves of apb_wdata.
- R7: Address bits 16:10 give the slot index. Only apb_sel bit [index] rises, and no more than one select bit is ever high.
- R8: A transfer is refused if its address bits 31:17 differ from the region base, if it targets a slot whose mask bit is 0 (slot 127 by default), or if ahb_size is above 2. A refused transfer gives one cycle with ahb_ready_out 0 and ahb_resp 1, then one cycle with both at 1, and no select line rises.
- R9: Inside the word-only window (slots 45 to 50 by default), byte and halfword accesses are refused as in R8, while word accesses complete normally.
- R10: A cycle in which ahb_sel is 0, or ahb_trans bit 1 is 0, starts nothing. ahb_ready_out stays 1, ahb_resp stays 0, and apb_sel stays zero.
- R11: While apb_enable is high and apb_ready is low, apb_enable stays high and apb_addr, apb_wdata and apb_write hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared AHB/APB clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ahb_sel | input | 1 | Slave select from the AHB decoder |
| ahb_addr | input | ADDR_W | Transfer address |
| ahb_trans | input | 2 | Transfer type; bit 1 set means a real transfer |
| ahb_write | input | 1 | 1 for write |
| ahb_size | input | 3 | 0 byte, 1 halfword, 2 word |
| ahb_wdata | input | 32 | Write data, valid in the data phase |
| ahb_ready_in | input | 1 | Bus-wide ready from the AHB mux |
| ahb_ready_out | output | 1 | This slave's ready |
| ahb_resp | output | 1 | 1 for ERROR response |
| ahb_rdata | output | 32 | Read data |
| apb_sel | output | NUM_SLOTS | One-hot peripheral select |
| apb_enable | output | 1 | Access-phase strobe |
| apb_addr | output | ADDR_W | Word-aligned APB address |
| apb_write | output | 1 | APB direction |
| apb_wdata | output | 32 | Lane-filled write data |
| apb_ready | input | 1 | Peripheral ready |
| apb_rdata | input | 32 | Peripheral read data |

## Verification
On every cycle, the embedded properties check the following:
- The select vector is never more than one-hot.
- Setup is always followed by access with a stable select.
- The access phase holds its address, data and direction while the peripheral stalls.
- The AHB side is held off while an APB transfer is open.
- Error responses come as a two-cycle pair with no select raised.
- A byte write always carries four equal lanes.

Only the bench scenarios can show the values themselves:
- Which slot a given address selects.
- Which byte or halfword lane is copied for each offset.
- That refused slots, the window, out-of-region addresses and oversize transfers are all refused.
- That read data arrives in the exact cycle the peripheral becomes ready.

// File: rtl/apb_bridge_pkg.sv
package apb_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_SETUP,
        ST_ACCESS,
        ST_ERR_WAIT,
        ST_ERR_DONE
    } bridge_state_t;

    localparam logic [2:0] SZ_BYTE = 3'd0;
    localparam logic [2:0] SZ_HALF = 3'd1;
    localparam logic [2:0] SZ_WORD = 3'd2;

endpackage

// File: rtl/apb_slot_decode.sv
module apb_slot_decode
    import apb_bridge_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SLOT_BITS = 10,
    parameter int NUM_SLOTS = 128,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 32'h4000_0000,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK = {NUM_SLOTS{1'b1}},
    parameter int WO_FIRST  = 45,
    parameter int WO_LAST   = 50,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic [IDX_W-1:0]  slot_idx,
    output logic              reject
);
    localparam int REGION_LSB = SLOT_BITS + IDX_W;
    localparam logic [IDX_W-1:0] WO_LO = IDX_W'(WO_FIRST);
    localparam logic [IDX_W-1:0] WO_HI = IDX_W'(WO_LAST);

    logic in_region;
    logic slot_used;
    logic in_window;
    logic too_wide;
    logic sub_word;

    always_comb begin
        slot_idx  = addr[REGION_LSB-1:SLOT_BITS];
        in_region = (addr[ADDR_W-1:REGION_LSB] == BASE_ADDR[ADDR_W-1:REGION_LSB]);
        slot_used = SLOT_MASK[slot_idx];
        in_window = (slot_idx >= WO_LO) && (slot_idx <= WO_HI);
        too_wide  = (size > SZ_WORD);
        sub_word  = (size != SZ_WORD);
        reject    = !in_region || !slot_used || too_wide || (in_window && sub_word);
    end

endmodule

// File: rtl/apb_lane_replicate.sv
module apb_lane_replicate
    import apb_bridge_pkg::*;
(
    input  logic [31:0] narrow_data,
    input  logic [1:0]  lane,
    input  logic [2:0]  size,
    output logic [31:0] wide_data
);
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    always_comb begin
        unique case (lane)
            2'd0: pick_b = narrow_data[7:0];
            2'd1: pick_b = narrow_data[15:8];
            2'd2: pick_b = narrow_data[23:16];
            2'd3: pick_b = narrow_data[31:24];
            default: pick_b = narrow_data[7:0];
        endcase
        pick_h = lane[1] ? narrow_data[31:16] : narrow_data[15:0];
        if (size == SZ_BYTE)
            wide_data = {4{pick_b}};
        else if (size == SZ_HALF)
            wide_data = {2{pick_h}};
        else
            wide_data = narrow_data;
    end

endmodule

// File: rtl/apb_lane_bridge.sv
module apb_lane_bridge
    import apb_bridge_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SLOT_BITS = 10,
    parameter int NUM_SLOTS = 128,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 32'h4000_0000,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK = {1'b0, {(NUM_SLOTS-1){1'b1}}},
    parameter int WO_FIRST  = 45,
    parameter int WO_LAST   = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ahb_sel,
    input  logic [ADDR_W-1:0]    ahb_addr,
    input  logic [1:0]           ahb_trans,
    input  logic                 ahb_write,
    input  logic [2:0]           ahb_size,
    input  logic [31:0]          ahb_wdata,
    input  logic                 ahb_ready_in,
    output logic                 ahb_ready_out,
    output logic                 ahb_resp,
    output logic [31:0]          ahb_rdata,
    output logic [NUM_SLOTS-1:0] apb_sel,
    output logic                 apb_enable,
    output logic [ADDR_W-1:0]    apb_addr,
    output logic                 apb_write,
    output logic [31:0]          apb_wdata,
    input  logic                 apb_ready,
    input  logic [31:0]          apb_rdata
);
    localparam int IDX_W = $clog2(NUM_SLOTS);

    bridge_state_t state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [2:0]        size_q;
    logic [IDX_W-1:0]  slot_q;
    logic [31:0]       wdata_q;

    logic [IDX_W-1:0]  dec_slot;
    logic              dec_reject;
    logic [31:0]       filled;
    logic              accept;
    logic              apb_open;
    bridge_state_t     route;

    apb_slot_decode #(
        .ADDR_W    (ADDR_W),
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS),
        .BASE_ADDR (BASE_ADDR),
        .SLOT_MASK (SLOT_MASK),
        .WO_FIRST  (WO_FIRST),
        .WO_LAST   (WO_LAST)
    ) u_decode (
        .addr     (ahb_addr),
        .size     (ahb_size),
        .slot_idx (dec_slot),
        .reject   (dec_reject)
    );

    apb_lane_replicate u_fill (
        .narrow_data (ahb_wdata),
        .lane        (addr_q[1:0]),
        .size        (size_q),
        .wide_data   (filled)
    );

    // transfer acceptance and the state it leads to
    always_comb begin
        accept = ahb_sel && ahb_trans[1] && ahb_ready_in && ahb_ready_out;
        if (dec_reject)
            route = ST_ERR_WAIT;
        else if (ahb_write)
            route = ST_CAPTURE;
        else
            route = ST_SETUP;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = accept ? route : ST_IDLE;
            ST_CAPTURE:  state_nx = ST_SETUP;
            ST_SETUP:    state_nx = ST_ACCESS;
            ST_ACCESS:   if (apb_ready) state_nx = accept ? route : ST_IDLE;
            ST_ERR_WAIT: state_nx = ST_ERR_DONE;
            ST_ERR_DONE: state_nx = accept ? route : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // address-phase and data-phase capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= SZ_WORD;
            slot_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= ahb_addr;
                write_q <= ahb_write;
                size_q  <= ahb_size;
                slot_q  <= dec_slot;
            end
            if (state == ST_CAPTURE)
                wdata_q <= filled;
        end
    end

    // outputs
    always_comb begin
        ahb_ready_out = 1'b1;
        ahb_resp      = 1'b0;
        apb_open      = 1'b0;
        apb_enable    = 1'b0;
        unique case (state)
            ST_IDLE:     ahb_ready_out = 1'b1;
            ST_CAPTURE:  ahb_ready_out = 1'b0;
            ST_SETUP: begin
                ahb_ready_out = 1'b0;
                apb_open      = 1'b1;
            end
            ST_ACCESS: begin
                ahb_ready_out = apb_ready;
                apb_open      = 1'b1;
                apb_enable    = 1'b1;
            end
            ST_ERR_WAIT: begin
                ahb_ready_out = 1'b0;
                ahb_resp      = 1'b1;
            end
            ST_ERR_DONE: begin
                ahb_ready_out = 1'b1;
                ahb_resp      = 1'b1;
            end
            default:     ahb_ready_out = 1'b1;
        endcase
        apb_addr  = {addr_q[ADDR_W-1:2], 2'b00};
        apb_write = write_q;
        apb_wdata = wdata_q;
        ahb_rdata = apb_rdata;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign apb_sel[g] = apb_open && (slot_q == IDX_W'(g));
    end

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(apb_sel));

    // R2
    setup_to_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !apb_enable) |=> (apb_enable && $stable(apb_sel) && $stable(apb_addr)));

    // R11
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_enable && !apb_ready) |=>
            (apb_enable && $stable(apb_addr) && $stable(apb_wdata) && $stable(apb_write)));

    // R3
    wait_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_sel && !(apb_enable && apb_ready)) |-> !ahb_ready_out);

    // R8
    err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_resp && !ahb_ready_out) |=> (ahb_resp && ahb_ready_out));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_resp |-> (apb_sel == '0));

    // R5
    byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_write && |apb_sel && size_q == SZ_BYTE) |->
            (apb_wdata[31:24] == apb_wdata[7:0] && apb_wdata[23:16] == apb_wdata[7:0]
             && apb_wdata[15:8] == apb_wdata[7:0]));

endmodule

// File: tb/test_apb_lane_bridge.sv
module test_apb_lane_bridge;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ahb_sel = 1'b0;
    logic [31:0]  ahb_addr = '0;
    logic [1:0]   ahb_trans = 2'b00;
    logic         ahb_write = 1'b0;
    logic [2:0]   ahb_size = 3'd2;
    logic [31:0]  ahb_wdata = '0;
    logic         ahb_ready_in = 1'b1;
    logic         ahb_ready_out;
    logic         ahb_resp;
    logic [31:0]  ahb_rdata;
    logic [127:0] apb_sel;
    logic         apb_enable;
    logic [31:0]  apb_addr;
    logic         apb_write;
    logic [31:0]  apb_wdata;
    logic         apb_ready = 1'b0;
    logic [31:0]  apb_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    apb_lane_bridge i_apb_lane_bridge (
        .clk, .rst_n, .ahb_sel, .ahb_addr, .ahb_trans, .ahb_write, .ahb_size,
        .ahb_wdata, .ahb_ready_in, .ahb_ready_out, .ahb_resp, .ahb_rdata,
        .apb_sel, .apb_enable, .apb_addr, .apb_write, .apb_wdata,
        .apb_ready, .apb_rdata
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_fill(input logic [31:0] a, input logic [2:0] sz,
                                               input logic [31:0] d);
        int sh;
        if (sz == 3'd0) begin
            sh = 8 * int'(a[1:0]);
            return ((d >> sh) & 32'hFF) * 32'h0101_0101;
        end
        if (sz == 3'd1) begin
            sh = 16 * int'(a[1]);
            return ((d >> sh) & 32'hFFFF) * 32'h0001_0001;
        end
        return d;
    endfunction

    // One transfer, checked cycle by cycle against the behavioural expectation.
    task automatic xfer(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                        input logic [31:0] d, input int waits, input logic refuse,
                        input string req);
        logic [127:0] exp_sel;
        exp_sel = 128'(1) << a[16:10];
        ahb_sel = 1'b1; ahb_trans = 2'b10; ahb_addr = a; ahb_write = wr; ahb_size = sz;
        #1;
        chk(req, "addr-phase ready", 128'(ahb_ready_out), 128'(1));
        @(negedge clk);
        ahb_sel = 1'b0; ahb_trans = 2'b00;
        if (refuse) begin
            #1;
            chk(req, "err1 ready", 128'(ahb_ready_out), 128'(0));
            chk(req, "err1 resp", 128'(ahb_resp), 128'(1));
            chk(req, "err1 sel", apb_sel, '0);
            @(negedge clk); #1;
            chk(req, "err2 ready", 128'(ahb_ready_out), 128'(1));
            chk(req, "err2 resp", 128'(ahb_resp), 128'(1));
            chk(req, "err2 sel", apb_sel, '0);
            @(negedge clk); #1;
            chk(req, "after err resp", 128'(ahb_resp), 128'(0));
            return;
        end
        if (wr) begin
            ahb_wdata = d;
            #1;
            chk("R3", "capture ready", 128'(ahb_ready_out), 128'(0));
            chk(req, "capture sel", apb_sel, '0);
            @(negedge clk);
            ahb_wdata = 32'h5A5A_A5A5;
        end
        #1;
        chk("R7", "setup sel", apb_sel, exp_sel);
        chk("R2", "setup enable", 128'(apb_enable), 128'(0));
        chk("R3", "setup ready", 128'(ahb_ready_out), 128'(0));
        chk(req, "setup addr", 128'(apb_addr), 128'(a & 32'hFFFF_FFFC));
        chk(req, "setup write", 128'(apb_write), 128'(wr));
        if (wr) chk(req, "setup wdata", 128'(apb_wdata), 128'(model_fill(a, sz, d)));
        @(negedge clk);
        for (int k = 0; k <= waits; k++) begin
            apb_ready = (k == waits);
            apb_rdata = (k == waits) ? d : ~d;
            #1;
            chk("R2", "access enable", 128'(apb_enable), 128'(1));
            chk("R11", "access sel", apb_sel, exp_sel);
            chk("R11", "access addr", 128'(apb_addr), 128'(a & 32'hFFFF_FFFC));
            if (wr) chk("R11", "access wdata", 128'(apb_wdata), 128'(model_fill(a, sz, d)));
            chk("R3", "access ready", 128'(ahb_ready_out), 128'(k == waits));
            if (!wr && k == waits) chk("R3", "rdata", 128'(ahb_rdata), 128'(d));
            @(negedge clk);
        end
        apb_ready = 1'b0;
        #1;
        chk(req, "after sel", apb_sel, '0);
        chk(req, "after ready", 128'(ahb_ready_out), 128'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "reset ready", 128'(ahb_ready_out), 128'(1));
        chk("R1", "reset resp", 128'(ahb_resp), 128'(0));
        chk("R1", "reset sel", apb_sel, '0);
        chk("R1", "reset enable", 128'(apb_enable), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R10: unselected and idle-type cycles start nothing
        ahb_sel = 1'b0; ahb_trans = 2'b10; ahb_addr = 32'h4000_0400; ahb_write = 1'b0;
        @(negedge clk);
        ahb_sel = 1'b1; ahb_trans = 2'b00;
        @(negedge clk);
        ahb_sel = 1'b1; ahb_trans = 2'b01;
        @(negedge clk);
        ahb_sel = 1'b0; ahb_trans = 2'b00;
        #1;
        chk("R10", "idle ready", 128'(ahb_ready_out), 128'(1));
        chk("R10", "idle resp", 128'(ahb_resp), 128'(0));
        chk("R10", "idle sel", apb_sel, '0);
        @(negedge clk);

        xfer(32'h4000_0C04, 3'd2, 1'b0, 32'hCAFE_1234, 0, 1'b0, "R2");
        xfer(32'h4001_9008, 3'd2, 1'b0, 32'h0BAD_F00D, 3, 1'b0, "R11");
        xfer(32'h4000_2810, 3'd2, 1'b1, 32'h89AB_CDEF, 1, 1'b0, "R4");
        for (int l = 0; l < 4; l++)
            xfer(32'h4000_5400 + 32'(l), 3'd0, 1'b1, 32'h4433_2211, l, 1'b0, "R5");
        xfer(32'h4000_3800, 3'd1, 1'b1, 32'hBBBB_AAAA, 0, 1'b0, "R6");
        xfer(32'h4000_3802, 3'd1, 1'b1, 32'h7766_5544, 2, 1'b0, "R6");
        xfer(32'h4001_FC00, 3'd2, 1'b0, 32'h1, 0, 1'b1, "R8");
        xfer(32'h5000_0000, 3'd2, 1'b1, 32'h2, 0, 1'b1, "R8");
        xfer(32'h4000_0000, 3'd3, 1'b0, 32'h3, 0, 1'b1, "R8");
        xfer(32'h4000_B803, 3'd0, 1'b1, 32'h4, 0, 1'b1, "R9");
        xfer(32'h4000_C802, 3'd1, 1'b0, 32'h5, 0, 1'b1, "R9");
        xfer(32'h4000_B404, 3'd2, 1'b1, 32'h1357_9BDF, 1, 1'b0, "R9");
        xfer(32'h4001_FBFC, 3'd0, 1'b1, 32'hF0E1_D2C3, 0, 1'b0, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule